// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 512K bytes. The host gives one word per request: a strobe, a read/write select, a 19-bit byte address and, for writes, one data byte. The controller turns each request into control waveforms for the memory: an active-low chip select, write strobe and output enable, plus a data output with its own drive enable. For a read it captures the returned byte and reports it with a one-cycle valid pulse.

Every nanosecond limit of the memory is a parameter. Each is converted to a whole number of clock cycles by rounding up, with a minimum of one. A write pulls chip select and the write strobe low on the same edge and lets both rise together, so that edge ends the write. Data drive begins only after the memory has had time to release the bus. Output enable stays high for the whole write. A write that directly follows a read gets one idle turnaround cycle. After reset, the controller accepts no request until one memory cycle time has passed.

Top module: `asram_ctrl`

## Requirements
- R1: During reset and while idle, chip select, write strobe and output enable are all high (1) and the data drive enable is low.
- R2: After reset is released, `ready` stays low for NPU = ceil(TCYC_NS/CLK_NS) clock edges and then goes high. With the default parameters NPU is 4.
- R3: A read holds chip select and output enable low, with the write strobe high and the address steady, for NRD = max(ceil cycle time, ceil address access, ceil output-enable access) cycles. The read byte is registered on the edge that ends that window. `rd_valid` pulses high for exactly one cycle after that edge. The default NRD is 4, so `rd_valid` appears 4 cycles after acceptance.
- R4: A write holds chip select and the write strobe low together for exactly NWR = max(ceil pulse width, ceil select-to-end, ceil address-to-end, ceil release + ceil data setup) cycles, and both rise on the same edge. The default NWR is 4.
- R5: In a write, the data drive enable rises ceil(write-to-release) cycles after the write strobe falls. It is high for NWR minus that count cycles before the write strobe rises (2 by default), and it stays high for the cycle after the rise.
- R6: Output enable is high whenever the write strobe is low. The controller never drives data while the memory may be driving the bus.
- R7: A write accepted right after a read gets one extra cycle with all strobes high before the write strobe falls. A default write then takes 6 cycles from acceptance to `ready`, instead of 5.
- R8: `ready` is low from request acceptance until the whole access, including recovery and turnaround, has finished. It is never high while chip select is low.
- R9: Every access occupies at least the memory cycle time. A write adds max(1, NCYC - NWR) recovery cycles after the write strobe rises.
- R10: Every byte written to any 19-bit address reads back unchanged, including address 0 and address 0x7FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe; taken on an edge where `ready` is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | High when a request can be accepted |
| rd_valid | output | 1 | One-cycle pulse with the captured read byte |
| rd_data | output | 8 | Captured read byte |
| mem_addr | output | 19 | Address to the memory |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 8 | Data sampled from the memory |

## Verification
The hardest case to reach from the ports is a late read sample or a shortened write window. Both stay invisible while a memory model simply returns stored data. The bench model therefore returns a poison byte until the address has been held under an active read for the full access time. It measures each write strobe window and each data setup window at mid-cycle and stores a byte only when the strobe rises. A write issued directly after a read exercises the turnaround path. The model also tracks the memory's bus release tail after output enable rises, which exposes any premature data drive.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WR,
    ST_WREC
  } asram_st_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_cnt.sv
module asram_cnt #(
  parameter int W       = 4,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= W'(RST_VAL);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/asram_rdcap.sv
module asram_rdcap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      vld  <= 1'b0;
    end else begin
      vld <= cap;
      if (cap) dout <= din;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int AW      = 19,
  parameter int DW      = 8,
  parameter int CLK_NS  = 4,
  parameter int TCYC_NS = 15,  // minimum read/write cycle
  parameter int TAA_NS  = 15,  // address / select to data
  parameter int TOE_NS  = 6,   // output enable to data
  parameter int TWP_NS  = 8,   // write strobe pulse
  parameter int TCW_NS  = 12,  // select low to write end
  parameter int TAW_NS  = 8,   // address valid to write end
  parameter int TDS_NS  = 7,   // data setup to write end
  parameter int TWZ_NS  = 6    // write strobe low to memory release
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  import asram_pkg::*;

  localparam int NCYC = ns2cyc(TCYC_NS, CLK_NS);
  localparam int NAA  = ns2cyc(TAA_NS, CLK_NS);
  localparam int NOE  = ns2cyc(TOE_NS, CLK_NS);
  localparam int NWP  = ns2cyc(TWP_NS, CLK_NS);
  localparam int NCW  = ns2cyc(TCW_NS, CLK_NS);
  localparam int NAW  = ns2cyc(TAW_NS, CLK_NS);
  localparam int NDS  = ns2cyc(TDS_NS, CLK_NS);
  localparam int NWZ  = ns2cyc(TWZ_NS, CLK_NS);
  localparam int NRD  = max2(NCYC, max2(NAA, NOE));
  localparam int NWR  = max2(max2(NWP, NCW), max2(NAW, NWZ + NDS));
  localparam int NREC = max2(1, NCYC - NWR);
  localparam int NPU  = NCYC;
  localparam int NMAX = max2(max2(NRD, NWR), max2(NREC, NPU));
  localparam int CW   = $clog2(NMAX + 1);

  asram_st_e     state_q;
  logic          last_rd_q;
  logic [DW-1:0] wdata_q;
  logic [CW-1:0] ph_cnt, boot_cnt, ph_val;
  logic          ph_load, ph_zero, boot_done;

  // named events, also observed by the checker
  logic ev_accept, ev_rd_start, ev_wr_start, ev_rd_sample, ev_wr_end, ev_drive_on;

  asram_cnt #(.W(CW), .RST_VAL(NPU)) u_boot (
    .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0), .cnt(boot_cnt)
  );

  asram_cnt #(.W(CW), .RST_VAL(0)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .cnt(ph_cnt)
  );

  asram_rdcap #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap(ev_rd_sample), .din(mem_dq_i),
    .dout(rd_data), .vld(rd_valid)
  );

  assign boot_done    = (boot_cnt == '0);
  assign ph_zero      = (ph_cnt == '0);
  assign ready        = (state_q == ST_IDLE) && boot_done;
  assign ev_accept    = ready && req;
  assign ev_rd_start  = ev_accept && !req_we;
  assign ev_wr_start  = (ev_accept && req_we && !last_rd_q) || (state_q == ST_TURN);
  assign ev_rd_sample = (state_q == ST_RD) && ph_zero;
  assign ev_wr_end    = (state_q == ST_WR) && ph_zero;
  assign ev_drive_on  = (state_q == ST_WR) && (ph_cnt == CW'(NWR - NWZ));
  assign mem_dq_o     = wdata_q;

  always_comb begin
    ph_load = ev_rd_start || ev_wr_start || ev_wr_end;
    if (ev_rd_start)      ph_val = CW'(NRD - 1);
    else if (ev_wr_start) ph_val = CW'(NWR - 1);
    else                  ph_val = CW'(NREC - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      last_rd_q <= 1'b0;
      wdata_q   <= '0;
      mem_addr  <= '0;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (ev_accept) begin
          mem_addr <= req_addr;
          wdata_q  <= req_wdata;
          if (!req_we) begin
            mem_cs_n <= 1'b0;
            mem_oe_n <= 1'b0;
            state_q  <= ST_RD;
          end else if (last_rd_q) begin
            state_q  <= ST_TURN;
          end else begin
            mem_cs_n <= 1'b0;
            mem_we_n <= 1'b0;
            state_q  <= ST_WR;
          end
        end
        ST_TURN: begin
          mem_cs_n  <= 1'b0;
          mem_we_n  <= 1'b0;
          last_rd_q <= 1'b0;
          state_q   <= ST_WR;
        end
        ST_RD: if (ph_zero) begin
          mem_cs_n  <= 1'b1;
          mem_oe_n  <= 1'b1;
          last_rd_q <= 1'b1;
          state_q   <= ST_IDLE;
        end
        ST_WR: begin
          if (ev_drive_on) mem_dq_oe <= 1'b1;
          if (ph_zero) begin
            mem_cs_n <= 1'b1;
            mem_we_n <= 1'b1;
            state_q  <= ST_WREC;
          end
        end
        ST_WREC: if (ph_zero) begin
          mem_dq_oe <= 1'b0;
          last_rd_q <= 1'b0;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int NWR = 4,
  parameter int NDS = 2,
  parameter int NPU = 4
) (
  input logic clk,
  input logic rst_n,
  input logic ready,
  input logic rd_valid,
  input logic mem_cs_n,
  input logic mem_we_n,
  input logic mem_oe_n,
  input logic mem_dq_oe
);
  logic [15:0] boot_n, wlen, dlen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_n <= '0;
      wlen   <= '0;
      dlen   <= '0;
    end else begin
      if (boot_n < 16'(NPU)) boot_n <= boot_n + 1'b1;
      wlen <= mem_we_n ? '0 : wlen + 1'b1;
      dlen <= mem_we_n ? '0 : (mem_dq_oe ? dlen + 1'b1 : dlen);
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));
  p_boot_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_n < 16'(NPU)) |-> (!ready && mem_cs_n));
  p_rdv_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_we_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);
  p_wr_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wlen >= 16'(NWR) && mem_cs_n));
  p_data_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (dlen >= 16'(NDS) && mem_dq_oe));
  p_oe_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  p_no_contend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |=> mem_we_n);
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !ready);
endmodule

bind asram_ctrl asram_ctrl_chk #(.NWR(NWR), .NDS(NDS), .NPU(NPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .rd_valid(rd_valid),
  .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;
  localparam int CLKP   = 4;
  localparam int B_CYC  = (15 + CLKP - 1) / CLKP;
  localparam int B_AA   = (15 + CLKP - 1) / CLKP;
  localparam int B_WZ   = (6 + CLKP - 1) / CLKP;
  localparam int B_OZ   = (5 + CLKP - 1) / CLKP;
  localparam int B_NRD  = 4;
  localparam int B_NWR  = 4;
  localparam int B_NWRT = 5;  // write accept to ready
  localparam int B_NTRN = 6;  // write after read

  logic clk = 0, rst_n = 0;
  logic req = 0, req_we = 0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic ready, rd_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rd_data, mem_dq_o, mem_dq_i;
  logic [18:0] mem_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLKP/2) clk = ~clk;

  asram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // behavioural memory, sampled mid-cycle
  logic [7:0] mem [int unsigned];
  logic [7:0] sb  [int unsigned];
  int age = 0, tail = 0, wlen = 0, dlen = 0;
  bit prev_wr = 0, oe_bad = 0;
  logic [18:0] prev_addr = '0;
  logic [7:0] dq_model = 8'hEE;
  assign mem_dq_i = dq_model;

  always @(negedge clk) begin
    bit drv, wr;
    if (rst_n) begin
      drv = !mem_cs_n && !mem_oe_n && mem_we_n;
      wr  = !mem_cs_n && !mem_we_n;
      if (mem_dq_oe && (drv || tail > 0))
        chk(0, "R6 contention", tail, 0);
      if (drv) tail = B_OZ; else if (tail > 0) tail--;
      if (drv && mem_addr == prev_addr) age++; else if (drv) age = 1; else age = 0;
      prev_addr = mem_addr;
      if (drv && age >= B_AA && age >= B_CYC && mem.exists(int'(mem_addr)))
        dq_model = mem[int'(mem_addr)];
      else
        dq_model = 8'hEE;
      if (wr) begin
        wlen++;
        if (mem_dq_oe) dlen++;
        if (!mem_oe_n) oe_bad = 1;
      end
      if (!mem_we_n && mem_cs_n) chk(0, "R4 strobe outside select", 1, 0);
      if (prev_wr && !wr) begin
        chk(wlen == B_NWR && mem_cs_n && mem_we_n, "R4 write window", wlen, B_NWR);
        chk(dlen == B_NWR - B_WZ, "R5 data setup", dlen, B_NWR - B_WZ);
        chk(mem_dq_oe, "R5 data hold", mem_dq_oe, 1);
        chk(!oe_bad, "R6 oe during write", oe_bad, 0);
        mem[int'(mem_addr)] = mem_dq_o;
        wlen = 0; dlen = 0; oe_bad = 0;
      end
      prev_wr = wr;
    end
  end

  task automatic issue(input bit we, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1; req_we = we; req_addr = a; req_wdata = d;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 0;
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d, input int exp_n);
    int n = 0;
    issue(1, a, d);
    chk(!ready, "R8 busy after accept", ready, 0);
    do begin @(negedge clk); n++; end while (!ready && n < 50);
    chk(n == exp_n, (exp_n == B_NTRN) ? "R7 turnaround length" : "R9 write length", n, exp_n);
    sb[int'(a)] = d;
  endtask

  task automatic do_read(input logic [18:0] a);
    int n = 0;
    issue(0, a, 8'h00);
    do begin @(negedge clk); n++; end while (!rd_valid && n < 50);
    chk(n == B_NRD, "R3 read latency", n, B_NRD);
    chk(rd_data == sb[int'(a)], "R10 read data", rd_data, sb[int'(a)]);
    chk(ready, "R8 ready after read", ready, 1);
    @(negedge clk);
    chk(!rd_valid, "R3 valid pulse width", rd_valid, 0);
  endtask

  initial begin
    int n;
    logic [18:0] addrs [21];
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !ready && !rd_valid,
        "R1 reset state", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, ready}, 5'b11100);
    rst_n = 1;
    n = 0;
    do begin @(negedge clk); n++;
      if (!ready) chk(mem_cs_n && mem_oe_n && mem_we_n, "R1 quiet in lockout", mem_cs_n, 1);
    end while (!ready && n < 50);
    chk(n == B_CYC, "R2 power-up lockout", n, B_CYC);

    addrs[0] = 19'h00000;
    addrs[1] = 19'h7FFFF;
    for (int i = 0; i < 19; i++) addrs[i+2] = 19'(1) << i;
    for (int i = 0; i < 21; i++) do_write(addrs[i], 8'((i * 37 + 5) ^ (i << 4)), B_NWRT);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle after writes", mem_cs_n, 1);
    for (int i = 0; i < 21; i++) do_read(addrs[i]);
    // write right after a read, then overwrite and read back
    do_write(19'h2AAAA, 8'h5A, B_NTRN);
    do_write(19'h55555, 8'hA5, B_NWRT);
    do_read(19'h2AAAA);
    do_write(19'h00000, 8'hC3, B_NTRN);
    do_read(19'h00000);
    do_read(19'h55555);
    do_read(19'h7FFFF);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R8 actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule